// File: doc/BRIEF.md
# Nibble-Parallel Transmit Payload Port

This block takes transmit payload from terminal equipment four bits at a time and turns it into a serial bit stream for a downstream frame builder. It has one clock, the fast transmit clock. From that clock it makes a nibble clock at one quarter of the rate and drives it out to the terminal equipment. Each payload nibble is taken in at the rising edge of that nibble clock. All logic stays in the transmit clock domain: a one-cycle capture enable marks the transmit-clock edge at which the nibble clock rises.

A position counter gives every captured nibble a place in an 1176-nibble frame, numbered 0 to 1175. A 2-bit timing-reference select input sets how that counter is aligned:

- **Frame-slave:** the terminal equipment sends a frame-reference pulse with nibble 0, and the block follows it.
- **Frame-master:** the block keeps its own count and tells the terminal equipment when to present nibble 0.

A misplaced reference pulse realigns the counter and raises a sticky flag, which stays set until a clear input removes it.

The serial side is a stream interface with a valid strobe and no ready. The nibble rate is fixed by the transmit clock, so there is no back-pressure. The consumer must accept every bit for which `bit_valid_o` is high. Likewise, the terminal equipment must present each nibble in time for the nibble-clock edge, because the input side has no handshake.

Top module: `nibtx_port`

## Requirements
- R1: A synchronous active-high reset clears the divider, the serializer and the misalignment flag, so `nib_clk_o`, `bit_valid_o` and `misalign_o` are low. After reset the frame position is the one before nibble 0. The first captured nibble is therefore nibble 0 and carries `bit_fstart_o`, and `fstart_o` is high after reset while master mode is selected.
- R2: While `nib_sel_i` is high, `nib_clk_o` has a period of four transmit clocks. It is low for the first two cycles after reset or after enable, then high for two cycles, and so on.
- R3: The value on `nib_data_i` at the transmit-clock edge where `nib_clk_o` rises is the nibble that is captured.
- R4: Each captured nibble goes out on `bit_o` most significant bit first. The bits appear in the four cycles that follow the capture edge, and `bit_valid_o` is high for exactly those cycles.
- R5: Nibble positions count from 0 to 1175 and then wrap to 0. `bit_fstart_o` is high only on the first bit of a nibble at position 0.
- R6: Any select value other than 2'b01 gives master mode. In master mode, `fstart_o` is high for the whole nibble period whose closing capture edge takes nibble 0, that is, from the capture of nibble 1175 to the capture of nibble 0.
- R7: With `tref_sel_i` = 2'b01 (slave mode), `fref_i` high at a capture edge makes the captured nibble position 0.
- R8: In slave mode, a reference at a capture edge whose previous nibble was not 1175 sets `misalign_o`, and the flag stays set. A reference that follows nibble 1175 does not set it.
- R9: `clr_misalign_i` high at an edge clears `misalign_o`, unless a misaligned reference sets the flag at the same edge. In that case setting wins.
- R10: In master mode `fref_i` is ignored. It causes no realignment and does not set `misalign_o`.
- R11: With `nib_sel_i` low, the divider is held, `nib_clk_o` stays low, nothing is captured and the frame position holds. Bits already loaded still drain, and then `bit_valid_o` goes low.
- R12: `fstart_o` stays low in slave mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock, the only timing reference |
| rst | input | 1 | Synchronous active-high reset |
| nib_sel_i | input | 1 | High enables nibble-parallel operation |
| tref_sel_i | input | 2 | Timing-reference select; 2'b01 is frame-slave, any other value is frame-master |
| nib_data_i | input | 4 | Payload nibble from the terminal equipment |
| fref_i | input | 1 | Frame reference from the terminal equipment (slave mode) |
| clr_misalign_i | input | 1 | Clears the sticky misalignment flag |
| nib_clk_o | output | 1 | Nibble clock, transmit clock divided by four |
| fstart_o | output | 1 | Master mode: high during the nibble period for nibble 0 |
| bit_o | output | 1 | Serial payload bit |
| bit_valid_o | output | 1 | `bit_o` carries a payload bit |
| bit_fstart_o | output | 1 | Current bit is the first bit of frame nibble 0 |
| misalign_o | output | 1 | Sticky: a slave reference arrived off the frame boundary |

## Verification
The bench runs the block through more than one full 1176-nibble frame in master mode, so the wrap from 1175 to 0 is seen twice. A counter that is off by one would move the frame-start bit and `fstart_o` by one nibble. In slave mode it places a reference exactly after nibble 1175 and another in mid-frame. A design that compared against the wrong position would either flag the aligned pulse or miss the misaligned one. It also tests a reference pulse in master mode, a clear that coincides with a new misalignment, and an enable gap during which the divider and the count must freeze while the last nibble drains. A divider that kept running, or a counter that kept counting, would shift all later nibble positions.

// File: rtl/nibtx_pkg.sv
package nibtx_pkg;
  localparam int unsigned NIB_W         = 4;
  localparam int unsigned FRAME_NIBBLES = 1176;
  localparam logic [1:0]  TREF_SLAVE    = 2'b01;

  typedef struct packed {
    logic valid;
    logic data;
    logic sof;
  } ser_bit_t;
endpackage

// File: rtl/nibtx_clkdiv.sv
module nibtx_clkdiv #(
  parameter int unsigned DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  output logic nclk_o,
  output logic cap_en_o
);
  localparam int unsigned PW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST_PH = PW'(DIV - 1);
  localparam logic [PW-1:0] PRE_RISE = PW'(DIV / 2 - 1);
  localparam logic [PW-1:0] HIGH_PH = PW'(DIV / 2);

  logic [PW-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
    end else if (!run_i) begin
      phase_q <= '0;
    end else if (phase_q == LAST_PH) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_q + PW'(1);
    end
  end

  // Upper half of the phase range is the high half of the nibble clock.
  assign nclk_o   = (phase_q >= HIGH_PH);
  // This edge moves the phase into the high half, i.e. the nibble-clock rise.
  assign cap_en_o = run_i && (phase_q == PRE_RISE);
endmodule

// File: rtl/nibtx_frame_ctr.sv
module nibtx_frame_ctr #(
  parameter int unsigned FRAME_N = 1176
) (
  input  logic clk,
  input  logic rst,
  input  logic cap_en_i,
  input  logic slave_i,
  input  logic fref_i,
  input  logic clr_i,
  output logic at_last_o,
  output logic pos_zero_o,
  output logic misalign_o
);
  localparam int unsigned CW = $clog2(FRAME_N);
  localparam logic [CW-1:0] LAST_IDX = CW'(FRAME_N - 1);

  logic [CW-1:0] idx_q;
  logic [CW-1:0] idx_next;
  logic          realign;
  logic          mis_q;

  assign at_last_o = (idx_q == LAST_IDX);
  assign realign   = cap_en_i && slave_i && fref_i;

  always_comb begin
    if (realign || at_last_o) begin
      idx_next = '0;
    end else begin
      idx_next = idx_q + CW'(1);
    end
  end

  assign pos_zero_o = (idx_next == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= LAST_IDX;
    end else if (cap_en_i) begin
      idx_q <= idx_next;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mis_q <= 1'b0;
    end else if (realign && !at_last_o) begin
      mis_q <= 1'b1;
    end else if (clr_i) begin
      mis_q <= 1'b0;
    end
  end

  assign misalign_o = mis_q;
endmodule

// File: rtl/nibtx_serializer.sv
module nibtx_serializer
  import nibtx_pkg::*;
#(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] din_i,
  input  logic         sof_i,
  output ser_bit_t     out_o
);
  localparam int unsigned LW = $clog2(W + 1);

  logic [W-1:0]  sh_q;
  logic [LW-1:0] left_q;
  logic          sof_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '0;
      left_q <= '0;
      sof_q  <= 1'b0;
    end else if (load_i) begin
      sh_q   <= din_i;
      left_q <= LW'(W);
      sof_q  <= sof_i;
    end else if (left_q != '0) begin
      sh_q   <= {sh_q[W-2:0], 1'b0};
      left_q <= left_q - LW'(1);
      sof_q  <= 1'b0;
    end
  end

  assign out_o.valid = (left_q != '0);
  assign out_o.data  = sh_q[W-1];
  assign out_o.sof   = sof_q;
endmodule

// File: rtl/nibtx_port.sv
module nibtx_port
  import nibtx_pkg::*;
#(
  parameter int unsigned NW      = NIB_W,
  parameter int unsigned FRAME_N = FRAME_NIBBLES
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          nib_sel_i,
  input  logic [1:0]    tref_sel_i,
  input  logic [NW-1:0] nib_data_i,
  input  logic          fref_i,
  input  logic          clr_misalign_i,
  output logic          nib_clk_o,
  output logic          fstart_o,
  output logic          bit_o,
  output logic          bit_valid_o,
  output logic          bit_fstart_o,
  output logic          misalign_o
);
  // One serial bit per transmit clock: divide ratio equals nibble width.
  localparam int unsigned DIV = NW;

  logic     cap_en;
  logic     slave;
  logic     at_last;
  logic     pos_zero;
  ser_bit_t ser;

  assign slave = (tref_sel_i == TREF_SLAVE);

  nibtx_clkdiv #(.DIV(DIV)) u_div (
    .clk      (clk),
    .rst      (rst),
    .run_i    (nib_sel_i),
    .nclk_o   (nib_clk_o),
    .cap_en_o (cap_en)
  );

  nibtx_frame_ctr #(.FRAME_N(FRAME_N)) u_ctr (
    .clk        (clk),
    .rst        (rst),
    .cap_en_i   (cap_en),
    .slave_i    (slave),
    .fref_i     (fref_i),
    .clr_i      (clr_misalign_i),
    .at_last_o  (at_last),
    .pos_zero_o (pos_zero),
    .misalign_o (misalign_o)
  );

  nibtx_serializer #(.W(NW)) u_ser (
    .clk    (clk),
    .rst    (rst),
    .load_i (cap_en),
    .din_i  (nib_data_i),
    .sof_i  (pos_zero),
    .out_o  (ser)
  );

  assign bit_o        = ser.data;
  assign bit_valid_o  = ser.valid;
  assign bit_fstart_o = ser.sof;
  assign fstart_o     = nib_sel_i && !slave && at_last;
endmodule

// File: rtl/nibtx_port_chk.sv
module nibtx_port_chk (
  input logic       clk,
  input logic       rst,
  input logic       nib_sel_i,
  input logic [1:0] tref_sel_i,
  input logic       fref_i,
  input logic       clr_misalign_i,
  input logic       nib_clk_o,
  input logic       bit_valid_o,
  input logic       bit_fstart_o,
  input logic       misalign_o
);
  p_valid_on_rise_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(nib_clk_o) |-> bit_valid_o);

  p_sof_is_valid_r5: assert property (@(posedge clk) disable iff (rst)
    bit_fstart_o |-> bit_valid_o);

  p_sof_at_rise_r5: assert property (@(posedge clk) disable iff (rst)
    bit_fstart_o |-> $rose(nib_clk_o));

  p_mis_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (misalign_o && !clr_misalign_i) |=> misalign_o);

  p_mis_clear_r9: assert property (@(posedge clk) disable iff (rst)
    (clr_misalign_i && !fref_i) |=> !misalign_o);

  p_master_no_mis_r10: assert property (@(posedge clk) disable iff (rst)
    (tref_sel_i != 2'b01 && !misalign_o) |=> !misalign_o);

  p_idle_clk_low_r11: assert property (@(posedge clk) disable iff (rst)
    !nib_sel_i |=> !nib_clk_o);
endmodule

bind nibtx_port nibtx_port_chk u_chk (
  .clk            (clk),
  .rst            (rst),
  .nib_sel_i      (nib_sel_i),
  .tref_sel_i     (tref_sel_i),
  .fref_i         (fref_i),
  .clr_misalign_i (clr_misalign_i),
  .nib_clk_o      (nib_clk_o),
  .bit_valid_o    (bit_valid_o),
  .bit_fstart_o   (bit_fstart_o),
  .misalign_o     (misalign_o)
);

// File: tb/nibtx_port_test.sv
module nibtx_port_test;
  logic       clk = 1'b0;
  logic       rst, nib_sel, fref, clr;
  logic [1:0] tref_sel;
  logic [3:0] nib_data;
  logic       nib_clk, fstart, bit_s, bit_v, bit_sof, mis;

  always #10 clk = ~clk;

  nibtx_port uut (
    .clk(clk), .rst(rst), .nib_sel_i(nib_sel), .tref_sel_i(tref_sel),
    .nib_data_i(nib_data), .fref_i(fref), .clr_misalign_i(clr),
    .nib_clk_o(nib_clk), .fstart_o(fstart), .bit_o(bit_s),
    .bit_valid_o(bit_v), .bit_fstart_o(bit_sof), .misalign_o(mis)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  // Behavioural reference model
  int m_ph, m_idx;
  bit mq_b[$];
  bit mq_s[$];
  bit m_mis;

  always @(posedge clk) begin
    if (rst) begin
      m_ph = 0; m_idx = 1175; m_mis = 0;
      mq_b.delete(); mq_s.delete();
    end else begin
      bit cap, setm;
      int nid;
      cap = nib_sel && (m_ph == 1);
      setm = 0;
      m_ph = nib_sel ? (m_ph + 1) % 4 : 0;
      if (cap) begin
        if (tref_sel == 2'b01 && fref) begin
          if (m_idx != 1175) setm = 1;
          nid = 0;
        end else begin
          nid = (m_idx == 1175) ? 0 : m_idx + 1;
        end
        m_idx = nid;
        mq_b.delete(); mq_s.delete();
        for (int i = 3; i >= 0; i--) begin
          mq_b.push_back(nib_data[i]);
          mq_s.push_back(i == 3 && nid == 0);
        end
      end else if (mq_b.size() > 0) begin
        void'(mq_b.pop_front());
        void'(mq_s.pop_front());
      end
      if (setm) m_mis = 1;
      else if (clr) m_mis = 0;
    end
  end

  task automatic chk(string tag, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%0b exp=%0b at cycle %0d", tag, what, act, exp, cyc);
    end
  endtask

  // Per-cycle comparison, mid high phase
  always @(posedge clk) begin
    #5;
    if (!rst) begin
      chk("R2", "nib_clk", nib_clk, m_ph >= 2);
      chk("R4", "bit_valid", bit_v, mq_b.size() > 0);
      if (mq_b.size() > 0) chk("R3", "bit", bit_s, mq_b[0]);
      chk("R5", "bit_fstart", bit_sof, (mq_b.size() > 0) && mq_s[0]);
      chk("R6", "fstart", fstart, nib_sel && tref_sel != 2'b01 && m_idx == 1175);
      chk("R8", "misalign", mis, m_mis);
    end
  end

  always @(negedge clk) nib_data = 4'($urandom());

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      errors++;
      $display("FAIL watchdog act=running exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // Raise fref for the capture that follows nibble position `want`.
  task automatic pulse_ref(int want, bit do_clr);
    do @(negedge clk); while (!(m_ph == 1 && m_idx == want));
    fref = 1; clr = do_clr;
    @(posedge clk); #5;
    if (tref_sel == 2'b01) chk("R7", "sof after reference", bit_sof, 1'b1);
    @(negedge clk);
    fref = 0; clr = 0;
  endtask

  initial begin
    rst = 1; nib_sel = 1; tref_sel = 2'b00; fref = 0; clr = 0;
    repeat (3) @(negedge clk);
    chk("R1", "reset nib_clk", nib_clk, 1'b0);
    chk("R1", "reset bit_valid", bit_v, 1'b0);
    chk("R1", "reset misalign", mis, 1'b0);
    chk("R1", "reset fstart", fstart, 1'b1);
    rst = 0;
    do @(negedge clk); while (!bit_v);
    chk("R1", "first nibble is frame start", bit_sof, 1'b1);

    // Master: two full frames plus margin
    repeat (1176 * 4 * 2 + 20) @(negedge clk);

    // R10: reference pulses in master mode are ignored
    pulse_ref(300, 0);
    repeat (8) @(negedge clk);
    chk("R10", "master ignores fref", mis, 1'b0);

    // Slave mode
    tref_sel = 2'b01;
    do @(negedge clk); while (m_idx != 1175);
    chk("R12", "fstart low in slave", fstart, 1'b0);
    pulse_ref(1175, 0);
    chk("R8", "aligned ref no flag", mis, 1'b0);
    pulse_ref(500, 0);
    chk("R8", "misaligned ref sets flag", mis, 1'b1);
    repeat (40) @(negedge clk);
    chk("R8", "flag sticky", mis, 1'b1);
    clr = 1; @(negedge clk); clr = 0;
    chk("R9", "clear", mis, 1'b0);
    pulse_ref(20, 1);
    chk("R9", "set wins over clear", mis, 1'b1);
    clr = 1; @(negedge clk); clr = 0;
    repeat (1176 * 4 + 40) @(negedge clk);

    // R11: enable gap
    nib_sel = 0;
    repeat (8) @(negedge clk);
    chk("R11", "nib_clk idle", nib_clk, 1'b0);
    chk("R11", "drained", bit_v, 1'b0);
    repeat (30) @(negedge clk);
    nib_sel = 1;
    tref_sel = 2'b10;
    repeat (1176 * 4 + 100) @(negedge clk);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule